// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single-word requests from a CPU-side port into cycles on an external memory bus. It drives the address, an address strobe, separate read and write strobes, and a chip select for one expansion area. A basic cycle has three states, T1, T2 and T3. Wait states (Tw) can be placed between T2 and T3. A programmed count of 0 to 3 waits always comes first. When pin-wait mode is on, more waits follow for as long as the external wait pin is seen asserted. The pin is sampled at the falling clock edge in T2 and in every Tw.

The external space can be treated as burst ROM. In that case, sequential instruction fetches inside an aligned block of 4 or 8 words finish in shortened accesses of 1 or 2 states. The first fetch of a run always uses a full normal cycle. Data reads and writes never use burst accesses, and any of them ends a run.

A request is presented on `req_i` for one cycle while `busy_o` is low. `done_o` then pulses for one cycle, and for reads `rdata_o` holds the word captured at the end of the access. In this document, latency N means that `done_o` is high in the Nth cycle after the cycle in which `req_i` was presented.

Top module: `ebus_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `as_o`, `rd_o`, `wr_o` and `cs_o` are low. The programmed wait count starts at 3, so a read made before any configuration write has latency 7.
- R2: A normal cycle behaves as follows:
  - T1 asserts `as_o` with `rd_o` and `wr_o` low.
  - `as_o` stays high through T3.
  - For a read, `rd_o` is high from T2 through T3.
  - Latency is 4 plus the number of wait states.
  - `bus_addr_o` carries the request address from T1 on.
- R3: With pin-wait mode off, exactly the programmed count W (0 to 3) of wait states is inserted, and the wait pin has no effect on latency.
- R4: With pin-wait mode on, suppose the wait pin is held asserted from the request cycle up to and including the cycle that is X cycles after T2 began (X=0 means never asserted). Latency is then 4 + max(W, X). Programmed waits come first and pin waits follow.
- R5: In a write, `wr_o` is high in T2 and in every Tw, and low in T3. `rd_o` stays low, and `bus_wdata_o` carries the request data.
- R6: `rdata_o` holds the value of `bus_rdata_i` as sampled at the end of T3, or at the end of the last burst state. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R7: An access whose top 2 address bits equal 2'b11 (the expansion area) behaves as follows:
  - If the expansion chip-select enable is set, `as_o` is never asserted and `cs_o` is high in every state of the access.
  - If the enable is clear, `as_o` behaves as in R2 and `cs_o` stays low.
- R8: With burst mode on and 1-state burst timing, a fetch qualifies for a burst access when:
  - its address is the previous fetch address plus 1, and
  - it lies in the same aligned block.
  A qualifying fetch has latency 2, with `rd_o` high and `as_o` low in its single state.
- R9: With 2-state burst timing, each qualifying burst access has latency 3.
- R10: The burst block size is selected by a configuration bit:
  - with the bit clear, blocks are aligned 4-word blocks (address bits [1:0] index a word in the block);
  - with the bit set, blocks are aligned 8-word blocks (address bits [2:0]);
  - a fetch that crosses into the next block uses a normal cycle.
- R11: Any of the following uses a normal cycle:
  - a fetch that is not sequential;
  - a data read or a write;
  - any fetch while burst mode is off.
  
  A data access also ends the run, so the next sequential fetch after it is normal.
- R12: The first fetch of a burst run uses a full normal cycle, including all its wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Load the configuration inputs |
| cfg_waits_i | input | 2 | Programmed wait count, 0 to 3 |
| cfg_pin_wait_i | input | 1 | Enable pin-sampled waits after the programmed ones |
| cfg_burst_en_i | input | 1 | Treat the external space as burst ROM |
| cfg_burst8_i | input | 1 | Burst block of 8 words (else 4) |
| cfg_burst_2st_i | input | 1 | Burst access takes 2 states (else 1) |
| cfg_exp_cs_en_i | input | 1 | Expansion-area chip select enable |
| req_i | input | 1 | Request strobe, one cycle, only while idle |
| addr_i | input | AW | Request word address |
| we_i | input | 1 | Request is a write |
| ifetch_i | input | 1 | Request is an instruction fetch |
| wdata_i | input | DW | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | External address |
| bus_wdata_o | output | DW | External write data |
| bus_rdata_i | input | DW | External read data |
| as_o | output | 1 | Address strobe, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| cs_o | output | 1 | Expansion-area chip select, active high |
| wait_i | input | 1 | External wait request, active high |

## Verification
Two situations are hard to reach from the ports. The first is the handover from programmed waits to pin waits. It only shows when the wait pin stays asserted past the last programmed Tw. The stimulus therefore varies the pin hold length X against the programmed count W, both above and below it, and compares latency with 4 + max(W, X). The second is the end of a burst run. It needs a run of sequential fetches that reaches a block boundary, or that is broken by a data read. Directed fetch sequences run for both block sizes and both burst timings.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;
  localparam int WAIT_W = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TW, S_T3, S_TB1, S_TB2
  } ebus_state_e;

  typedef struct packed {
    logic [WAIT_W-1:0] waits;
    logic              pin_wait;
    logic              burst_en;
    logic              burst8;
    logic              burst_2st;
    logic              exp_cs_en;
  } ebus_cfg_t;

  localparam ebus_cfg_t CFG_RESET = '{waits: '1, default: 1'b0};
endpackage

// File: rtl/ebus_cfg_reg.sv
`timescale 1ns/1ps
module ebus_cfg_reg
  import ebus_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  ebus_cfg_t cfg_d_i,
  output ebus_cfg_t cfg_o
);
  ebus_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (wr_i) cfg_q <= cfg_d_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ebus_wait_ctrl.sv
`timescale 1ns/1ps
module ebus_wait_ctrl #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,   // T1: clear count for the coming T2
  input  logic             phase_i,   // in T2 or Tw
  input  logic [CNT_W-1:0] prog_i,
  input  logic             pin_en_i,
  input  logic             wait_pin_i,
  output logic             more_o
);
  logic             pin_q;
  logic [CNT_W-1:0] cnt_q;

  // pin sampled mid-cycle on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= wait_pin_i;
  end

  assign more_o = phase_i && ((cnt_q < prog_i) || (pin_en_i && pin_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (start_i)                       cnt_q <= '0;
    else if (more_o && (cnt_q != '1))       cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/ebus_burst_track.sv
`timescale 1ns/1ps
module ebus_burst_track #(
  parameter int AW       = 16,
  parameter int BLK_S_LG = 2,
  parameter int BLK_L_LG = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ifetch_i,
  input  logic          we_i,
  input  logic          burst_en_i,
  input  logic          burst8_i,
  output logic          hit_o
);
  logic          live_q;
  logic [AW-1:0] last_q;
  logic [AW-1:0] seq_addr;
  logic          same_blk;
  int unsigned   lg;

  assign lg       = burst8_i ? BLK_L_LG : BLK_S_LG;
  assign seq_addr = last_q + AW'(1);
  assign same_blk = (addr_i >> lg) == (last_q >> lg);
  assign hit_o    = live_q && burst_en_i && ifetch_i && !we_i &&
                    (addr_i == seq_addr) && same_blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      last_q <= '0;
    end else if (acc_i) begin
      live_q <= burst_en_i && ifetch_i && !we_i;
      last_q <= addr_i;
    end
  end
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int                 AW        = 16,
  parameter int                 DW        = 16,
  parameter int                 EXP_TAG_W = 2,
  parameter logic [EXP_TAG_W-1:0] EXP_TAG = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic [1:0]    cfg_waits_i,
  input  logic          cfg_pin_wait_i,
  input  logic          cfg_burst_en_i,
  input  logic          cfg_burst8_i,
  input  logic          cfg_burst_2st_i,
  input  logic          cfg_exp_cs_en_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          ifetch_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          as_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          cs_o,
  input  logic          wait_i
);
  ebus_cfg_t   cfg_d, cfg_q;
  ebus_state_e state_q, state_d;
  logic          acc, hit, more, fin;
  logic          we_q, exp_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          in_norm, in_burst, supp;

  assign cfg_d = '{waits: cfg_waits_i, pin_wait: cfg_pin_wait_i,
                   burst_en: cfg_burst_en_i, burst8: cfg_burst8_i,
                   burst_2st: cfg_burst_2st_i, exp_cs_en: cfg_exp_cs_en_i};

  ebus_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .cfg_d_i (cfg_d),
    .cfg_o   (cfg_q)
  );

  ebus_wait_ctrl #(.CNT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (state_q == S_T1),
    .phase_i    ((state_q == S_T2) || (state_q == S_TW)),
    .prog_i     (cfg_q.waits),
    .pin_en_i   (cfg_q.pin_wait),
    .wait_pin_i (wait_i),
    .more_o     (more)
  );

  ebus_burst_track #(.AW(AW)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .addr_i     (addr_i),
    .ifetch_i   (ifetch_i),
    .we_i       (we_i),
    .burst_en_i (cfg_q.burst_en),
    .burst8_i   (cfg_q.burst8),
    .hit_o      (hit)
  );

  assign acc = (state_q == S_IDLE) && req_i;
  assign fin = (state_q == S_T3) || (state_q == S_TB2) ||
               ((state_q == S_TB1) && !cfg_q.burst_2st);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (req_i) state_d = hit ? S_TB1 : S_T1;
      S_T1:   state_d = S_T2;
      S_T2,
      S_TW:   state_d = more ? S_TW : S_T3;
      S_T3:   state_d = S_IDLE;
      S_TB1:  state_d = cfg_q.burst_2st ? S_TB2 : S_IDLE;
      S_TB2:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      exp_q   <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (acc) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
        exp_q   <= addr_i[AW-1 -: EXP_TAG_W] == EXP_TAG;
      end
      if (fin && !we_q) rdata_q <= bus_rdata_i;
    end
  end

  assign in_norm  = (state_q == S_T1) || (state_q == S_T2) ||
                    (state_q == S_TW) || (state_q == S_T3);
  assign in_burst = (state_q == S_TB1) || (state_q == S_TB2);
  assign supp     = exp_q && cfg_q.exp_cs_en;

  assign busy_o      = state_q != S_IDLE;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign as_o        = in_norm && !supp;
  assign rd_o        = !we_q && ((in_norm && state_q != S_T1) || in_burst);
  assign wr_o        = we_q && ((state_q == S_T2) || (state_q == S_TW));
  assign cs_o        = supp && (in_norm || in_burst);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R5
  AST_AS_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> !as_o); // R7
  AST_BURST_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TB1) |-> (rd_o && !as_o && !wr_o)); // R8
  AST_NO_SKIP_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_T3 && $past(state_q) == S_T2) |-> ($past(cfg_q.waits) == '0)); // R3
endmodule

// File: tb/ebus_seq_bench.sv
`timescale 1ns/1ps
module ebus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_waits = '0;
  logic        cfg_pin = 1'b0, cfg_be = 1'b0, cfg_b8 = 1'b0, cfg_b2 = 1'b0, cfg_ex = 1'b0;
  logic        req = 1'b0, we = 1'b0, ifetch = 1'b0, wait_pin = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        busy, done, as_s, rd_s, wr_s, cs_s;
  logic [15:0] rdata, bus_addr, bus_wdata, bus_rdata;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign bus_rdata = bus_addr ^ 16'hA5C3;

  ebus_seq u_ebus_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_waits_i(cfg_waits),
    .cfg_pin_wait_i(cfg_pin), .cfg_burst_en_i(cfg_be), .cfg_burst8_i(cfg_b8),
    .cfg_burst_2st_i(cfg_b2), .cfg_exp_cs_en_i(cfg_ex), .req_i(req),
    .addr_i(addr), .we_i(we), .ifetch_i(ifetch), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .as_o(as_s), .rd_o(rd_s),
    .wr_o(wr_s), .cs_o(cs_s), .wait_i(wait_pin)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int w, input bit p, input bit be, input bit b8,
                         input bit b2, input bit ex);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_waits = 2'(w); cfg_pin = p; cfg_be = be;
    cfg_b8 = b8; cfg_b2 = b2; cfg_ex = ex;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  // one access; x = wait pin hold length counted from T2
  task automatic run_acc(input logic [15:0] a, input logic w, input logic f,
                         input int x, input int lat_exp, input bit burst,
                         input bit supp, input string tag);
    logic [15:0] wd;
    int          lat;
    bit          got;
    logic [3:0]  stb;
    wd = 16'($urandom);
    got = 1'b0;
    lat = 0;
    @(posedge clk); #1;
    req = 1'b1; addr = a; we = w; ifetch = f; wdata = wd; wait_pin = (x > 0);
    for (int c = 1; c <= 40 && !got; c++) begin
      @(posedge clk); #1;
      req = 1'b0;
      wait_pin = (x > 0) && (c <= 1 + x);
      #2;
      stb = {as_s, rd_s, wr_s, cs_s};
      if (!burst) begin
        if (c == 1) chk(tag, "T1 strobes", stb, {!supp, 1'b0, 1'b0, supp});
        if (c == 2) begin
          chk(tag, "T2 strobes", stb, {!supp, !w, w, supp});
          chk(tag, "address", bus_addr, a);
          if (w) chk(tag, "write data", bus_wdata, wd);
        end
        if (c == lat_exp - 1) chk(tag, "T3 strobes", stb, {!supp, !w, 1'b0, supp});
      end else if (c == 1) begin
        chk(tag, "burst strobes", stb, {1'b0, 1'b1, 1'b0, supp});
        chk(tag, "burst address", bus_addr, a);
      end
      if (done) begin
        got = 1'b1;
        lat = c;
        chk(tag, "busy at done", busy, 0);
      end
    end
    chk(tag, "latency", lat, lat_exp);
    if (!w && got) chk(tag, "read data", rdata, a ^ 16'hA5C3);
    wait_pin = 1'b0;
  endtask

  function automatic int exp_lat(input int w, input bit p, input int x);
    if (p && x > w) return 4 + x;
    return 4 + w;
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    #9 rst_n = 1'b1;
    #2;
    chk("R1", "reset outputs", {busy, done, as_s, rd_s, wr_s, cs_s}, 0);
    run_acc(16'h1234, 1'b0, 1'b0, 0, 7, 1'b0, 1'b0, "R1");

    // R2 and R3 directed: every programmed count, pin off but held high
    for (int w = 0; w < 4; w++) begin
      set_cfg(w, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_acc(16'h0100 + 16'(w), 1'b0, 1'b0, 0, 4 + w, 1'b0, 1'b0, "R2");
      run_acc(16'h0200 + 16'(w), 1'b0, 1'b0, 5, 4 + w, 1'b0, 1'b0, "R3");
      run_acc(16'h0300 + 16'(w), 1'b1, 1'b0, 0, 4 + w, 1'b0, 1'b0, "R5");
    end
    // R4 directed: pin hold shorter and longer than programmed count
    set_cfg(2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_acc(16'h0400, 1'b0, 1'b0, 1, 6, 1'b0, 1'b0, "R4");
    run_acc(16'h0401, 1'b0, 1'b0, 5, 9, 1'b0, 1'b0, "R4");
    set_cfg(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_acc(16'h0402, 1'b1, 1'b0, 3, 7, 1'b0, 1'b0, "R4");

    // random mix of counts, pin mode, hold length and direction
    for (int i = 0; i < 40; i++) begin
      int  w, x;
      bit  p, wr;
      w  = int'($urandom_range(0, 3));
      p  = 1'($urandom_range(0, 1));
      x  = int'($urandom_range(0, 6));
      wr = 1'($urandom_range(0, 1));
      set_cfg(w, p, 1'b0, 1'b0, 1'b0, 1'b0);
      run_acc(16'($urandom) & 16'h7FFF, wr, 1'b0, x, exp_lat(w, p, x), 1'b0, 1'b0,
              wr ? "R5" : (p ? "R4" : "R6"));
    end

    // R7 expansion area
    set_cfg(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_acc(16'hC010, 1'b0, 1'b0, 0, 5, 1'b0, 1'b1, "R7");
    run_acc(16'hC020, 1'b1, 1'b0, 0, 5, 1'b0, 1'b1, "R7");
    run_acc(16'h4000, 1'b0, 1'b0, 0, 5, 1'b0, 1'b0, "R7");
    set_cfg(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_acc(16'hC030, 1'b0, 1'b0, 0, 5, 1'b0, 1'b0, "R7");

    // burst, 4-word block, 1-state
    set_cfg(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_acc(16'h0500, 1'b0, 1'b1, 0, 5, 1'b0, 1'b0, "R12");
    run_acc(16'h0501, 1'b0, 1'b1, 0, 2, 1'b1, 1'b0, "R8");
    run_acc(16'h0502, 1'b0, 1'b1, 0, 2, 1'b1, 1'b0, "R8");
    run_acc(16'h0503, 1'b0, 1'b1, 0, 2, 1'b1, 1'b0, "R8");
    run_acc(16'h0504, 1'b0, 1'b1, 0, 5, 1'b0, 1'b0, "R10");
    run_acc(16'h0505, 1'b0, 1'b1, 0, 2, 1'b1, 1'b0, "R8");
    run_acc(16'h0506, 1'b0, 1'b0, 0, 5, 1'b0, 1'b0, "R11");
    run_acc(16'h0507, 1'b0, 1'b1, 0, 5, 1'b0, 1'b0, "R11");
    run_acc(16'h0509, 1'b0, 1'b1, 0, 5, 1'b0, 1'b0, "R11");
    run_acc(16'h050A, 1'b1, 1'b0, 0, 5, 1'b0, 1'b0, "R11");
    // burst, 8-word block, 2-state, first fetch with waits
    set_cfg(3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    run_acc(16'h0600, 1'b0, 1'b1, 0, 7, 1'b0, 1'b0, "R12");
    for (int k = 1; k < 8; k++)
      run_acc(16'h0600 + 16'(k), 1'b0, 1'b1, 0, 3, 1'b1, 1'b0, "R9");
    run_acc(16'h0608, 1'b0, 1'b1, 0, 7, 1'b0, 1'b0, "R10");
    // burst off
    set_cfg(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_acc(16'h0700, 1'b0, 1'b1, 0, 4, 1'b0, 1'b0, "R11");
    run_acc(16'h0701, 1'b0, 1'b1, 0, 4, 1'b0, 1'b0, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule